// File: doc/BRIEF.md
# System Control Coprocessor

This block is the control coprocessor of a 64-bit processor core. It holds a bank of 32 control registers, each 64 bits wide, in which six have a fixed meaning: a free-running counter, a comparison value, the processor status, the interrupt cause, and two saved return addresses (one for ordinary exceptions and one for error-level exceptions). The pipeline hands it one decoded coprocessor instruction at a time. It carries out register moves in both directions and the return-from-exception instruction. Every other coprocessor operation is flagged as reserved.

Alongside the instruction path, the block runs a timer. A tick strobe advances the counter, and when the counter reaches the comparison value a timer bit is raised in the cause register. The block also computes a combined pending-interrupt level from the status and cause registers. Two pure lookups complete it. One says whether a given coprocessor may be used in the current status. The other maps a 32-bit virtual address in one of the two unmapped kernel windows to its physical address.

Move-from results and the return redirect appear in the same cycle as the instruction. Register updates take effect at the next clock edge.

Top module: `sysctl_cop`

## Requirements
- R1: After a synchronous active-low reset, every control register reads as zero and `pend_irq` is low.
- R2: When `instr_valid` is high with `op_rs`=00100, `gpr_value` is written to register `reg_sel` at the next edge. With `op_rs`=00000, `wb_valid` is high in the same cycle and `wb_data` is bits 31:0 of register `reg_sel` sign-extended to 64 bits. The full 64 bits are still stored.
- R3: A move-to into the cause register (index 13) changes only bits 9:8 and leaves every other cause bit as it was.
- R4: The count register (index 9) rises by one at each edge where `tick` is high. A move-to into Count in the same cycle takes priority over the tick.
- R5: When bits 31:0 of the incremented Count equal bits 31:0 of the stored compare register (index 11), cause bit 15 (the timer bit) is set.
- R6: A move-to into Compare clears cause bit 15 and stores the whole operand. If a timer match (R5) happens in the same cycle, the bit ends up set.
- R7: `pend_irq` is high exactly when status bit 0 (interrupt enable) is 1, status bits 1 (exception level) and 2 (error level) are both 0, and status bits 15:8 AND cause bits 15:8 is nonzero.
- R8: An exception return (`op_rs`=10000, `op_funct`=011000) with status bit 2 set drives `new_pc` from register 30 and clears status bit 2. `redirect` and `llbit_clr` pulse in the same cycle.
- R9: An exception return with status bit 2 clear drives `new_pc` from register 14 and clears status bit 1. `redirect` and `llbit_clr` pulse in the same cycle. They are low for every other instruction.
- R10: `cop_usable` is high when status bit 28+`cop_sel` is set, or when `cop_sel` is 0 and status bits 4:3 are 00 (kernel).
- R11: For `vaddr[31:29]`=100, `paddr` is `vaddr`−0x80000000. For 101, `paddr` is `vaddr`−0xA0000000. Any other value raises `addr_err`.
- R12: `rsvd_instr` is high in the same cycle for a valid instruction that is none of move-to, move-from, exception return, or TLB indexed write (`op_rs`=10000, `op_funct`=000010). The TLB indexed write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | A coprocessor instruction is presented this cycle |
| op_rs | input | 5 | Instruction sub-opcode field |
| op_funct | input | 6 | Function field for the coprocessor-operation group |
| reg_sel | input | 5 | Control register index |
| gpr_value | input | 64 | General register operand for move-to |
| tick | input | 1 | Timer advance strobe |
| cop_sel | input | 2 | Coprocessor number to test for usability |
| vaddr | input | 32 | Virtual address to translate |
| wb_data | output | 64 | Move-from result |
| wb_valid | output | 1 | `wb_data` is valid this cycle |
| new_pc | output | 64 | Exception return target |
| redirect | output | 1 | Fetch redirect pulse; also cancels a pending delay slot |
| llbit_clr | output | 1 | Clear the load-linked bit |
| rsvd_instr | output | 1 | Reserved coprocessor instruction |
| pend_irq | output | 1 | Combined pending interrupt |
| cop_usable | output | 1 | Selected coprocessor is usable |
| paddr | output | 32 | Physical address |
| addr_err | output | 1 | Address is outside both kernel windows |

## Verification
`wb_data`, `wb_valid`, `new_pc`, `redirect`, `llbit_clr` and `rsvd_instr` depend on the instruction in the same cycle, so the bench samples them 2 ns after it drives the inputs on the falling edge, before the next rising edge. Register writes, Count increments, timer-bit changes and status changes from a return land at the following rising edge. `pend_irq` is derived from those registers, so it is checked just after that edge, and register contents are checked with a move-from issued in the next cycle. `cop_usable`, `paddr` and `addr_err` are purely combinational and are checked a short settle time after their inputs change.

// File: rtl/sysctl_pkg.sv
// Shared constants for the system control coprocessor.
// Assumes the standard 5-bit sub-opcode and 6-bit function encodings.
package sysctl_pkg;
    localparam int XLEN   = 64;
    localparam int NREG   = 32;
    localparam int SEL_W  = $clog2(NREG);

    // Fixed register indices
    localparam logic [SEL_W-1:0] IDX_COUNT   = 5'd9;
    localparam logic [SEL_W-1:0] IDX_COMPARE = 5'd11;
    localparam logic [SEL_W-1:0] IDX_STATUS  = 5'd12;
    localparam logic [SEL_W-1:0] IDX_CAUSE   = 5'd13;
    localparam logic [SEL_W-1:0] IDX_EPC     = 5'd14;
    localparam logic [SEL_W-1:0] IDX_ERREPC  = 5'd30;

    // Sub-opcodes and functions
    localparam logic [4:0] RS_MOVE_FROM = 5'b00000;
    localparam logic [4:0] RS_MOVE_TO   = 5'b00100;
    localparam logic [4:0] RS_COP_OP    = 5'b10000;
    localparam logic [5:0] FN_TLB_WIDX  = 6'b000010;
    localparam logic [5:0] FN_EXC_RET   = 6'b011000;

    // Status bit positions
    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_KSU_LO = 3;
    localparam int ST_IM_LO  = 8;
    localparam int ST_CU_LO  = 28;

    // Cause bit positions and writable mask
    localparam int CA_IP_LO   = 8;
    localparam int CA_TIMER   = 15;
    localparam logic [XLEN-1:0] CAUSE_WMASK = 64'h0000_0000_0000_0300;

    typedef struct packed {
        logic mv_to;
        logic mv_from;
        logic tlb_widx;
        logic exc_ret;
        logic reserved;
    } sysctl_dec_t;
endpackage

// File: rtl/sysctl_decode.sv
// Instruction classifier: turns the sub-opcode and function fields into
// one-hot operation flags. Assumes fields are stable while instr_valid is high.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic        instr_valid,
    input  logic [4:0]  op_rs,
    input  logic [5:0]  op_funct,
    output sysctl_dec_t dec
);
    // Classify the presented instruction
    always_comb begin
        dec = '0;
        if (instr_valid) begin
            unique case (op_rs)
                RS_MOVE_TO:   dec.mv_to   = 1'b1;
                RS_MOVE_FROM: dec.mv_from = 1'b1;
                RS_COP_OP: begin
                    if (op_funct == FN_TLB_WIDX)     dec.tlb_widx = 1'b1;
                    else if (op_funct == FN_EXC_RET) dec.exc_ret  = 1'b1;
                    else                             dec.reserved = 1'b1;
                end
                default: dec.reserved = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
// Control register bank with the timer and return side effects.
// One generated register per index; special indices get their own update
// rules. Assumes move-to and exception return never coincide.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int N   = NREG,
    parameter int W   = XLEN,
    parameter int CMP_W = 32,
    localparam int SW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic          tick,
    input  logic          ret_en,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  status_q,
    output logic [W-1:0]  cause_q,
    output logic [W-1:0]  count_q,
    output logic [W-1:0]  epc_q,
    output logic [W-1:0]  errepc_q
);
    logic [W-1:0] regs_q [N];
    logic         count_wr;
    logic         compare_wr;
    logic [W-1:0] count_inc;
    logic         timer_hit;

    // Timer side conditions shared by Count and Cause
    always_comb begin
        count_wr   = wr_en && (wr_sel == IDX_COUNT);
        compare_wr = wr_en && (wr_sel == IDX_COMPARE);
        count_inc  = regs_q[IDX_COUNT] + W'(1);
        timer_hit  = tick && !count_wr &&
                     (count_inc[CMP_W-1:0] == regs_q[IDX_COMPARE][CMP_W-1:0]);
    end

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [SW-1:0] IDX = SW'(g);
        logic [W-1:0] q_r;
        logic [W-1:0] d_c;

        // Next-value selection for this register index
        always_comb begin
            d_c = q_r;
            if (wr_en && wr_sel == IDX) begin
                if (IDX == IDX_CAUSE) d_c = (q_r & ~CAUSE_WMASK) | (wr_data & CAUSE_WMASK);
                else                  d_c = wr_data;
            end
            if (IDX == IDX_COUNT && tick && !count_wr) d_c = count_inc;
            if (IDX == IDX_CAUSE) begin
                if (timer_hit)       d_c[CA_TIMER] = 1'b1;
                else if (compare_wr) d_c[CA_TIMER] = 1'b0;
            end
            if (IDX == IDX_STATUS && ret_en) begin
                if (q_r[ST_ERL]) d_c[ST_ERL] = 1'b0;
                else             d_c[ST_EXL] = 1'b0;
            end
        end

        // Register storage with synchronous clear
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_c;
        end

        assign regs_q[g] = q_r;
    end

    // Read port and named views
    assign rd_data  = regs_q[rd_sel];
    assign status_q = regs_q[IDX_STATUS];
    assign cause_q  = regs_q[IDX_CAUSE];
    assign count_q  = regs_q[IDX_COUNT];
    assign epc_q    = regs_q[IDX_EPC];
    assign errepc_q = regs_q[IDX_ERREPC];
endmodule

// File: rtl/sysctl_addr_map.sv
// Kernel unmapped-window translator: bits 31:29 pick the window; the two
// direct windows subtract their base, everything else is an error.
module sysctl_addr_map #(
    parameter int VA_W = 32
)(
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] paddr,
    output logic            addr_err
);
    localparam logic [VA_W-1:0] BASE_CACHED   = VA_W'(32'h8000_0000);
    localparam logic [VA_W-1:0] BASE_UNCACHED = VA_W'(32'hA000_0000);

    // Window decode and base subtraction
    always_comb begin
        paddr    = '0;
        addr_err = 1'b0;
        unique case (vaddr[VA_W-1 -: 3])
            3'b100:  paddr = vaddr - BASE_CACHED;
            3'b101:  paddr = vaddr - BASE_UNCACHED;
            default: addr_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/sysctl_cop.sv
// System control coprocessor top: decode, register bank, return redirect,
// interrupt combine, usability test and address translation.
// Assumes one instruction per cycle; outputs tied to the instruction are
// combinational, register effects land at the next edge.
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int VA_W = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [4:0]       op_rs,
    input  logic [5:0]       op_funct,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [XLEN-1:0]  gpr_value,
    input  logic             tick,
    input  logic [1:0]       cop_sel,
    input  logic [VA_W-1:0]  vaddr,
    output logic [XLEN-1:0]  wb_data,
    output logic             wb_valid,
    output logic [XLEN-1:0]  new_pc,
    output logic             redirect,
    output logic             llbit_clr,
    output logic             rsvd_instr,
    output logic             pend_irq,
    output logic             cop_usable,
    output logic [VA_W-1:0]  paddr,
    output logic             addr_err
);
    sysctl_dec_t     dec;
    logic [XLEN-1:0] rd_data;
    logic [XLEN-1:0] status_w;
    logic [XLEN-1:0] cause_w;
    logic [XLEN-1:0] count_w;
    logic [XLEN-1:0] epc_w;
    logic [XLEN-1:0] errepc_w;

    sysctl_decode u_dec (
        .instr_valid (instr_valid),
        .op_rs       (op_rs),
        .op_funct    (op_funct),
        .dec         (dec)
    );

    sysctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec.mv_to),
        .wr_sel   (reg_sel),
        .wr_data  (gpr_value),
        .tick     (tick),
        .ret_en   (dec.exc_ret),
        .rd_sel   (reg_sel),
        .rd_data  (rd_data),
        .status_q (status_w),
        .cause_q  (cause_w),
        .count_q  (count_w),
        .epc_q    (epc_w),
        .errepc_q (errepc_w)
    );

    sysctl_addr_map #(.VA_W(VA_W)) u_map (
        .vaddr    (vaddr),
        .paddr    (paddr),
        .addr_err (addr_err)
    );

    // Move-from result: low word sign-extended
    always_comb begin
        wb_valid = dec.mv_from;
        wb_data  = {{(XLEN-32){rd_data[31]}}, rd_data[31:0]};
    end

    // Exception return target and strobes
    always_comb begin
        redirect   = dec.exc_ret;
        llbit_clr  = dec.exc_ret;
        new_pc     = status_w[ST_ERL] ? errepc_w : epc_w;
        rsvd_instr = dec.reserved;
    end

    // Pending interrupt combine
    always_comb begin
        pend_irq = status_w[ST_IE] && !status_w[ST_EXL] && !status_w[ST_ERL] &&
                   |(status_w[ST_IM_LO +: 8] & cause_w[CA_IP_LO +: 8]);
    end

    // Coprocessor usability
    always_comb begin
        cop_usable = status_w[ST_CU_LO + int'(cop_sel)] ||
                     (cop_sel == 2'd0 && status_w[ST_KSU_LO +: 2] == 2'b00);
    end
endmodule

// File: rtl/sysctl_cop_chk.sv
// Property checker for sysctl_cop, attached by bind.
module sysctl_cop_chk
    import sysctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [4:0]       op_rs,
    input logic [SEL_W-1:0] reg_sel,
    input logic             tick,
    input logic [XLEN-1:0]  wb_data,
    input logic             wb_valid,
    input logic             redirect,
    input logic             llbit_clr,
    input logic             rsvd_instr,
    input logic             pend_irq,
    input logic [31:0]      paddr,
    input logic             addr_err,
    input logic [XLEN-1:0]  status_w,
    input logic [XLEN-1:0]  cause_w,
    input logic [XLEN-1:0]  count_w
);
    // R2
    sext_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data[63:32] == {32{wb_data[31]}}));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(instr_valid && op_rs == RS_MOVE_TO && reg_sel == IDX_COUNT))
        |=> count_w == $past(count_w) + 64'd1);

    // R7
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_irq |-> (status_w[ST_IE] && !status_w[ST_EXL] && !status_w[ST_ERL]));

    // R8
    erl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && status_w[ST_ERL]) |=> !status_w[ST_ERL]);

    // R9
    redirect_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (llbit_clr && instr_valid && !rsvd_instr && !wb_valid));

    // R11
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_err |-> paddr[31:29] == 3'b000);

    // R12
    rsvd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_instr |-> (instr_valid && !redirect));
endmodule

bind sysctl_cop sysctl_cop_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .op_rs       (op_rs),
    .reg_sel     (reg_sel),
    .tick        (tick),
    .wb_data     (wb_data),
    .wb_valid    (wb_valid),
    .redirect    (redirect),
    .llbit_clr   (llbit_clr),
    .rsvd_instr  (rsvd_instr),
    .pend_irq    (pend_irq),
    .paddr       (paddr),
    .addr_err    (addr_err),
    .status_w    (status_w),
    .cause_w     (cause_w),
    .count_w     (count_w)
);

// File: tb/sysctl_cop_tb_top.sv
// Directed bench for sysctl_cop: one task per scenario.
module sysctl_cop_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [4:0]  op_rs = '0;
    logic [5:0]  op_funct = '0;
    logic [4:0]  reg_sel = '0;
    logic [63:0] gpr_value = '0;
    logic        tick = 1'b0;
    logic [1:0]  cop_sel = '0;
    logic [31:0] vaddr = '0;
    logic [63:0] wb_data;
    logic        wb_valid;
    logic [63:0] new_pc;
    logic        redirect;
    logic        llbit_clr;
    logic        rsvd_instr;
    logic        pend_irq;
    logic        cop_usable;
    logic [31:0] paddr;
    logic        addr_err;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap_wb;
    logic [63:0] cap_pc;
    logic        cap_redir;
    logic        cap_ll;
    logic        cap_rsvd;

    localparam logic [4:0] MF = 5'b00000, MT = 5'b00100, CO = 5'b10000;

    always #10 clk = ~clk;

    sysctl_cop dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_rs(op_rs),
        .op_funct(op_funct), .reg_sel(reg_sel), .gpr_value(gpr_value),
        .tick(tick), .cop_sel(cop_sel), .vaddr(vaddr), .wb_data(wb_data),
        .wb_valid(wb_valid), .new_pc(new_pc), .redirect(redirect),
        .llbit_clr(llbit_clr), .rsvd_instr(rsvd_instr), .pend_irq(pend_irq),
        .cop_usable(cop_usable), .paddr(paddr), .addr_err(addr_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive on falling edge, capture same-cycle outputs, cross rising edge
    task automatic step(input bit v, input logic [4:0] rs, input logic [5:0] fn,
                        input logic [4:0] sel, input logic [63:0] d, input bit tk);
        @(negedge clk);
        instr_valid = v; op_rs = rs; op_funct = fn; reg_sel = sel; gpr_value = d; tick = tk;
        #2;
        cap_wb = wb_data; cap_pc = new_pc; cap_redir = redirect;
        cap_ll = llbit_clr; cap_rsvd = rsvd_instr;
        @(posedge clk);
        #1;
        instr_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [4:0] sel, input logic [63:0] d);
        step(1'b1, MT, 6'd0, sel, d, 1'b0);
    endtask

    task automatic rd_chk(input logic [4:0] sel, input logic [63:0] exp, input string req);
        step(1'b1, MF, 6'd0, sel, 64'd0, 1'b0);
        check(cap_wb === exp, req, cap_wb, exp);
    endtask

    task automatic t_reset();
        rd_chk(5'd9,  64'd0, "R1 count");
        rd_chk(5'd12, 64'd0, "R1 status");
        rd_chk(5'd13, 64'd0, "R1 cause");
        check(pend_irq === 1'b0, "R1 pend_irq", {63'd0, pend_irq}, 64'd0);
    endtask

    task automatic t_moves();
        wr(5'd14, 64'h0000_0001_8000_1234);
        rd_chk(5'd14, 64'hFFFF_FFFF_8000_1234, "R2 sign-extend negative");
        wr(5'd20, 64'hABCD_0000_1234_5678);
        rd_chk(5'd20, 64'h0000_0000_1234_5678, "R2 sign-extend positive");
        check(cap_redir === 1'b0, "R9 no redirect on move", {63'd0, cap_redir}, 64'd0);
    endtask

    task automatic t_cause_mask();
        wr(5'd13, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(5'd13, 64'h300, "R3 masked cause write");
        wr(5'd13, 64'd0);
        rd_chk(5'd13, 64'h0, "R3 cause cleared");
    endtask

    task automatic t_timer();
        wr(5'd9, 64'd0);
        wr(5'd11, 64'd3);
        step(1'b0, MF, 6'd0, 5'd0, 64'd0, 1'b1);
        step(1'b0, MF, 6'd0, 5'd0, 64'd0, 1'b0);
        step(1'b0, MF, 6'd0, 5'd0, 64'd0, 1'b1);
        rd_chk(5'd13, 64'h0, "R5 no match yet");
        step(1'b0, MF, 6'd0, 5'd0, 64'd0, 1'b1);
        rd_chk(5'd9, 64'd3, "R4 count after three ticks");
        rd_chk(5'd13, 64'h8000, "R5 timer bit set");
        step(1'b1, MT, 6'd0, 5'd9, 64'h55, 1'b1);
        rd_chk(5'd9, 64'h55, "R4 write beats tick");
    endtask

    task automatic t_pending();
        wr(5'd12, 64'h8001);
        check(pend_irq === 1'b1, "R7 enabled and pending", {63'd0, pend_irq}, 64'd1);
        wr(5'd12, 64'h8003);
        check(pend_irq === 1'b0, "R7 blocked by exception level", {63'd0, pend_irq}, 64'd0);
        wr(5'd12, 64'h0001);
        check(pend_irq === 1'b0, "R7 masked", {63'd0, pend_irq}, 64'd0);
        wr(5'd12, 64'h8001);
        wr(5'd11, 64'd100);
        check(pend_irq === 1'b0, "R6 compare write drops interrupt", {63'd0, pend_irq}, 64'd0);
        rd_chk(5'd13, 64'h0, "R6 timer bit cleared");
        wr(5'd9, 64'd99);
        step(1'b1, MT, 6'd0, 5'd11, 64'd100, 1'b1);
        rd_chk(5'd13, 64'h8000, "R6 match wins over compare write");
        wr(5'd11, 64'd0);
        wr(5'd12, 64'd0);
    endtask

    task automatic t_return();
        wr(5'd30, 64'h0000_0001_0000_0040);
        wr(5'd12, 64'h6);
        step(1'b1, CO, 6'b011000, 5'd0, 64'd0, 1'b0);
        check(cap_redir === 1'b1 && cap_ll === 1'b1, "R8 strobes", {62'd0, cap_redir, cap_ll}, 64'd3);
        check(cap_pc === 64'h0000_0001_0000_0040, "R8 error return target", cap_pc, 64'h0000_0001_0000_0040);
        rd_chk(5'd12, 64'h2, "R8 error level cleared only");
        step(1'b1, CO, 6'b011000, 5'd0, 64'd0, 1'b0);
        check(cap_pc === 64'h0000_0001_8000_1234, "R9 normal return target", cap_pc, 64'h0000_0001_8000_1234);
        check(cap_ll === 1'b1, "R9 link clear", {63'd0, cap_ll}, 64'd1);
        rd_chk(5'd12, 64'h0, "R9 exception level cleared");
    endtask

    task automatic t_usable();
        @(negedge clk); cop_sel = 2'd0; #2;
        check(cop_usable === 1'b1, "R10 kernel cop0", {63'd0, cop_usable}, 64'd1);
        cop_sel = 2'd1; #2;
        check(cop_usable === 1'b0, "R10 cop1 off", {63'd0, cop_usable}, 64'd0);
        wr(5'd12, 64'h10);
        cop_sel = 2'd0; #2;
        check(cop_usable === 1'b0, "R10 user cop0", {63'd0, cop_usable}, 64'd0);
        wr(5'd12, 64'h2000_0010);
        cop_sel = 2'd1; #2;
        check(cop_usable === 1'b1, "R10 cop1 enabled", {63'd0, cop_usable}, 64'd1);
        wr(5'd12, 64'h1000_0010);
        cop_sel = 2'd0; #2;
        check(cop_usable === 1'b1, "R10 cop0 enabled in user", {63'd0, cop_usable}, 64'd1);
        wr(5'd12, 64'd0);
    endtask

    task automatic t_addr();
        vaddr = 32'h8000_1000; #2;
        check(paddr === 32'h1000 && !addr_err, "R11 cached window", {32'd0, paddr}, 64'h1000);
        vaddr = 32'hA000_2000; #2;
        check(paddr === 32'h2000 && !addr_err, "R11 uncached window", {32'd0, paddr}, 64'h2000);
        vaddr = 32'h0000_1000; #2;
        check(addr_err === 1'b1, "R11 low error", {63'd0, addr_err}, 64'd1);
        vaddr = 32'hC000_0000; #2;
        check(addr_err === 1'b1, "R11 high error", {63'd0, addr_err}, 64'd1);
    endtask

    task automatic t_reserved();
        step(1'b1, CO, 6'b000001, 5'd0, 64'd0, 1'b0);
        check(cap_rsvd === 1'b1, "R12 unknown cop op", {63'd0, cap_rsvd}, 64'd1);
        wr(5'd12, 64'h4);
        step(1'b1, CO, 6'b000010, 5'd12, 64'hFF, 1'b0);
        check(cap_rsvd === 1'b0 && cap_redir === 1'b0, "R12 TLB write accepted", {62'd0, cap_rsvd, cap_redir}, 64'd0);
        rd_chk(5'd12, 64'h4, "R12 TLB write no effect");
        step(1'b1, 5'b00010, 6'd0, 5'd0, 64'd0, 1'b0);
        check(cap_rsvd === 1'b1, "R12 other sub-op", {63'd0, cap_rsvd}, 64'd1);
        step(1'b0, 5'b00010, 6'd0, 5'd0, 64'd0, 1'b0);
        check(cap_rsvd === 1'b0, "R12 idle not flagged", {63'd0, cap_rsvd}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_moves();
        t_cause_mask();
        t_timer();
        t_pending();
        t_return();
        t_usable();
        t_addr();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule